// File: doc/BRIEF.md
# Min-Sum Variable Node Processor

This block performs the update for a single variable node of a min-sum LDPC decoder. It receives one channel soft value and a set of check-to-variable messages, all short two's-complement words. It returns one outgoing message toward each connected check node, the full posterior sum, and the hard decision taken from that sum. The datapath forms one shared total sum. Each outgoing message is that total minus the message that arrived on the same edge, so a check node never gets its own information back. Each outgoing message is then clamped to the message word width.

The outputs are held in one register stage behind a valid/ready handshake. A decoder can time-share one instance across many variable nodes, or place one instance per node. Nodes whose degree is lower than the configured degree drive their spare message inputs to zero. The word width and the node degree are parameters. The internal sum width is derived from them so that the total sum cannot overflow.

Top module: `vnp_core`

## Requirements
- R1: Once an input is accepted, `total_sum` holds the two's-complement sum of `chan_llr` and every `chk_msg` field, all sign-extended, with no wrap.
- R2: Field j of `ext_msg` (bits j*MSG_W upward) equals `total_sum` minus `chk_msg` field j, clamped to the range -2^(MSG_W-1) .. 2^(MSG_W-1)-1 (-16..15 at the default width).
- R3: `hard_bit` is 1 when the registered total sum is negative and 0 when it is zero or positive.
- R4: An input is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. Its results appear on the outputs, with `out_valid` high, right after that edge: one cycle of latency.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `ext_msg`, `total_sum` and `hard_bit` stay unchanged.
- R6: After reset, `out_valid` is low and `total_sum` is zero.
- R7: When all `chk_msg` fields are zero, every `ext_msg` field equals `chan_llr` and `total_sum` equals `chan_llr`.
- R8: When the held result is taken (`out_valid` and `out_ready` high) and no new input is accepted at that edge, `out_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word set present |
| in_ready | output | 1 | Block can accept an input this cycle |
| chan_llr | input | MSG_W | Channel soft value, two's-complement |
| chk_msg | input | DEG*MSG_W | Incoming check messages, field j at bits j*MSG_W upward |
| out_valid | output | 1 | Output registers hold a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| ext_msg | output | DEG*MSG_W | Outgoing extrinsic messages, clamped, same field layout |
| total_sum | output | SUM_W | Full posterior sum, two's-complement |
| hard_bit | output | 1 | Sign of the posterior sum |

## Verification
The bench builds the block twice. The main instance uses a 3-bit word and degree 3. That makes the input space 4096 combinations, small enough to sweep completely, so every clamp edge, every sign crossing and the most negative total all occur. A second instance keeps the default 5-bit, degree-6 setting. It is driven with directed patterns: full-scale negative inputs, full-scale positive inputs, all-zero messages and a mixed case, which reach the 8-bit sum extremes and deep saturation. Stall, drain and reset behaviour are exercised on the small instance.

// File: rtl/vnp_pkg.sv
`timescale 1ns/1ps
package vnp_pkg;
  // Width that holds (deg+1) signed words of msg_w bits without overflow
  function automatic int sum_width(input int msg_w, input int deg);
    return msg_w + $clog2(deg + 1);
  endfunction
endpackage

// File: rtl/vnp_rst_sync.sv
`timescale 1ns/1ps
module vnp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vnp_sum_tree.sv
`timescale 1ns/1ps
module vnp_sum_tree #(
  parameter int MSG_W = 5,
  parameter int DEG   = 6,
  parameter int SUM_W = 8
) (
  input  logic [MSG_W-1:0]     chan,
  input  logic [DEG*MSG_W-1:0] msgs,
  output logic [SUM_W-1:0]     total
);
  localparam int EXT_W = SUM_W - MSG_W;

  logic [SUM_W-1:0] ext_w [DEG];

  for (genvar j = 0; j < DEG; j++) begin : g_ext
    assign ext_w[j] = {{EXT_W{msgs[j*MSG_W+MSG_W-1]}}, msgs[j*MSG_W +: MSG_W]};
  end

  always_comb begin
    total = {{EXT_W{chan[MSG_W-1]}}, chan};
    for (int j = 0; j < DEG; j++) begin
      total = total + ext_w[j];
    end
  end
endmodule

// File: rtl/vnp_extrinsic.sv
`timescale 1ns/1ps
module vnp_extrinsic #(
  parameter int MSG_W = 5,
  parameter int DEG   = 6,
  parameter int SUM_W = 8
) (
  input  logic [SUM_W-1:0]     total,
  input  logic [DEG*MSG_W-1:0] msgs,
  output logic [DEG*MSG_W-1:0] beta
);
  localparam int EXT_W = SUM_W - MSG_W;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << (MSG_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV - SUM_W'(1);

  for (genvar j = 0; j < DEG; j++) begin : g_edge
    logic signed [SUM_W-1:0] own_w;
    logic signed [SUM_W-1:0] diff_w;
    logic [MSG_W-1:0]        clip_w;

    assign own_w  = {{EXT_W{msgs[j*MSG_W+MSG_W-1]}}, msgs[j*MSG_W +: MSG_W]};
    assign diff_w = $signed(total) - own_w;

    always_comb begin
      if (diff_w > MAXV)      clip_w = MAXV[MSG_W-1:0];
      else if (diff_w < MINV) clip_w = MINV[MSG_W-1:0];
      else                    clip_w = diff_w[MSG_W-1:0];
    end

    assign beta[j*MSG_W +: MSG_W] = clip_w;
  end
endmodule

// File: rtl/vnp_core.sv
`timescale 1ns/1ps
module vnp_core #(
  parameter int MSG_W = 5,
  parameter int DEG   = 6,
  parameter int SUM_W = vnp_pkg::sum_width(MSG_W, DEG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [MSG_W-1:0]     chan_llr,
  input  logic [DEG*MSG_W-1:0] chk_msg,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DEG*MSG_W-1:0] ext_msg,
  output logic [SUM_W-1:0]     total_sum,
  output logic                 hard_bit
);
  logic                 srst_n;
  logic [SUM_W-1:0]     sum_d;
  logic [DEG*MSG_W-1:0] beta_d;
  logic                 load;
  logic                 vld_d;
  logic                 vld_q;
  logic [DEG*MSG_W-1:0] beta_q;
  logic [SUM_W-1:0]     sum_q;
  logic                 hard_q;

  vnp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  vnp_sum_tree #(.MSG_W(MSG_W), .DEG(DEG), .SUM_W(SUM_W)) u_sum (
    .chan  (chan_llr),
    .msgs  (chk_msg),
    .total (sum_d)
  );

  vnp_extrinsic #(.MSG_W(MSG_W), .DEG(DEG), .SUM_W(SUM_W)) u_ext (
    .total (sum_d),
    .msgs  (chk_msg),
    .beta  (beta_d)
  );

  // next state
  always_comb begin
    in_ready = srst_n && (!vld_q || out_ready);
    load     = in_valid && in_ready;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) vld_q <= 1'b0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      beta_q <= '0;
      sum_q  <= '0;
      hard_q <= 1'b0;
    end else if (load) begin
      beta_q <= beta_d;
      sum_q  <= sum_d;
      hard_q <= sum_d[SUM_W-1];
    end
  end

  assign out_valid = vld_q;
  assign ext_msg   = beta_q;
  assign total_sum = sum_q;
  assign hard_bit  = hard_q;
endmodule

// File: rtl/vnp_core_chk.sv
`timescale 1ns/1ps
module vnp_core_chk #(
  parameter int MSG_W = 5,
  parameter int DEG   = 6,
  parameter int SUM_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [MSG_W-1:0]     chan_llr,
  input logic [DEG*MSG_W-1:0] chk_msg,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DEG*MSG_W-1:0] ext_msg,
  input logic [SUM_W-1:0]     total_sum,
  input logic                 hard_bit
);
  localparam int HI = (1 << (MSG_W-1)) - 1;
  localparam int LO = -(1 << (MSG_W-1));

  logic [SUM_W-1:0]     ref_sum;
  logic [DEG*MSG_W-1:0] ref_beta;
  logic                 ref_neg;
  logic                 accept;

  always_comb begin
    int acc;
    int b;
    acc = int'($signed(chan_llr));
    for (int j = 0; j < DEG; j++) acc += int'($signed(chk_msg[j*MSG_W +: MSG_W]));
    ref_sum  = SUM_W'(acc);
    ref_neg  = (acc < 0);
    ref_beta = '0;
    for (int j = 0; j < DEG; j++) begin
      b = acc - int'($signed(chk_msg[j*MSG_W +: MSG_W]));
      if (b > HI) b = HI;
      if (b < LO) b = LO;
      ref_beta[j*MSG_W +: MSG_W] = MSG_W'(b);
    end
    accept = in_valid && in_ready;
  end

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> total_sum == $past(ref_sum)); // R1

  AST_EXT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ext_msg == $past(ref_beta)); // R2

  AST_HARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> hard_bit == $past(ref_neg)); // R3

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R4

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(ext_msg) && $stable(total_sum) && $stable(hard_bit)); // R5

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !accept) |=> !out_valid); // R8
endmodule

bind vnp_core vnp_core_chk #(.MSG_W(MSG_W), .DEG(DEG), .SUM_W(SUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .chan_llr  (chan_llr),
  .chk_msg   (chk_msg),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .ext_msg   (ext_msg),
  .total_sum (total_sum),
  .hard_bit  (hard_bit)
);

// File: tb/tb_vnp_core.sv
`timescale 1ns/1ps
module tb_vnp_core;
  localparam int SW = 3;
  localparam int SD = 3;
  localparam int SS = vnp_pkg::sum_width(SW, SD);
  localparam int WW = 5;
  localparam int WD = 6;
  localparam int WS = vnp_pkg::sum_width(WW, WD);

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // small instance
  logic            s_in_valid, s_in_ready, s_out_valid, s_out_ready, s_hard;
  logic [SW-1:0]   s_chan;
  logic [SD*SW-1:0] s_msg, s_ext;
  logic [SS-1:0]   s_sum;

  vnp_core #(.MSG_W(SW), .DEG(SD)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
    .chan_llr(s_chan), .chk_msg(s_msg), .out_valid(s_out_valid), .out_ready(s_out_ready),
    .ext_msg(s_ext), .total_sum(s_sum), .hard_bit(s_hard));

  // default-width instance
  logic            w_in_valid, w_in_ready, w_out_valid, w_out_ready, w_hard;
  logic [WW-1:0]   w_chan;
  logic [WD*WW-1:0] w_msg, w_ext;
  logic [WS-1:0]   w_sum;

  vnp_core #(.MSG_W(WW), .DEG(WD)) dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_in_valid), .in_ready(w_in_ready),
    .chan_llr(w_chan), .chk_msg(w_msg), .out_valid(w_out_valid), .out_ready(w_out_ready),
    .ext_msg(w_ext), .total_sum(w_sum), .hard_bit(w_hard));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampw(input int v, input int w);
    int hi = (1 << (w-1)) - 1;
    int lo = -(1 << (w-1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // drive at negedge, accepted at next posedge, checked at following negedge
  task automatic run_small(input int lam, input int a0, input int a1, input int a2, input string req);
    int a[3];
    int z;
    a[0] = a0; a[1] = a1; a[2] = a2;
    s_chan = SW'(lam);
    s_msg  = {SW'(a2), SW'(a1), SW'(a0)};
    s_in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    s_in_valid = 1'b0;
    z = lam + a0 + a1 + a2;
    chk("R4", "out_valid", int'(s_out_valid), 1);
    chk("R1", "total_sum", int'($signed(s_sum)), z);
    chk("R3", "hard_bit", int'(s_hard), (z < 0) ? 1 : 0);
    for (int j = 0; j < 3; j++)
      chk(req, "ext_msg", int'($signed(s_ext[j*SW +: SW])), clampw(z - a[j], SW));
  endtask

  task automatic run_wide(input int lam, input int a[6], input string req);
    int z;
    w_chan = WW'(lam);
    for (int j = 0; j < 6; j++) w_msg[j*WW +: WW] = WW'(a[j]);
    w_in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    w_in_valid = 1'b0;
    z = lam;
    for (int j = 0; j < 6; j++) z += a[j];
    chk("R4", "wide out_valid", int'(w_out_valid), 1);
    chk("R1", "wide total_sum", int'($signed(w_sum)), z);
    chk("R3", "wide hard_bit", int'(w_hard), (z < 0) ? 1 : 0);
    for (int j = 0; j < 6; j++)
      chk(req, "wide ext_msg", int'($signed(w_ext[j*WW +: WW])), clampw(z - a[j], WW));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int va[6];
    rst_n = 1'b0;
    s_in_valid = 1'b0; s_out_ready = 1'b1; s_chan = '0; s_msg = '0;
    w_in_valid = 1'b0; w_out_ready = 1'b1; w_chan = '0; w_msg = '0;
    repeat (3) @(negedge clk);
    chk("R6", "out_valid in reset", int'(s_out_valid), 0);
    chk("R6", "total_sum in reset", int'(s_sum), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6", "out_valid after reset", int'(s_out_valid), 0);
    chk("R6", "wide out_valid after reset", int'(w_out_valid), 0);

    // R2 exhaustive sweep over the small configuration
    for (int v = 0; v < 4096; v++) begin
      run_small(int'($signed(3'(v))), int'($signed(3'(v >> 3))),
                int'($signed(3'(v >> 6))), int'($signed(3'(v >> 9))), "R2");
    end

    // R7 zero messages, every channel value
    for (int l = -4; l < 4; l++) run_small(l, 0, 0, 0, "R7");

    // R8 drain with no new input
    @(negedge clk);
    chk("R8", "out_valid after drain", int'(s_out_valid), 0);

    // R5 stall: load A, hold, offer B
    s_out_ready = 1'b0;
    s_chan = 3'(2); s_msg = {3'(1), 3'(-3), 3'(-4)};
    s_in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    s_chan = 3'(-1); s_msg = {3'(3), 3'(3), 3'(3)};
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk("R5", "in_ready stalled", int'(s_in_ready), 0);
      chk("R5", "out_valid stalled", int'(s_out_valid), 1);
      chk("R5", "total_sum held", int'($signed(s_sum)), -4);
      chk("R5", "ext_msg field1 held", int'($signed(s_ext[3 +: 3])), -1);
    end
    s_out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    s_in_valid = 1'b0;
    chk("R5", "B accepted after release", int'($signed(s_sum)), 8);
    chk("R2", "B ext clamps high", int'($signed(s_ext[0 +: 3])), 3);
    @(posedge clk); @(negedge clk);
    chk("R8", "drain after B", int'(s_out_valid), 0);

    // default-width directed patterns
    for (int j = 0; j < 6; j++) va[j] = -16;
    run_wide(-16, va, "R2");
    for (int j = 0; j < 6; j++) va[j] = 15;
    run_wide(15, va, "R2");
    for (int j = 0; j < 6; j++) va[j] = 0;
    run_wide(-7, va, "R7");
    run_wide(15, va, "R7");
    va[0] = 3; va[1] = -2;
    run_wide(5, va, "R2");
    va[2] = -9; va[3] = 14; va[4] = -16; va[5] = 1;
    run_wide(-3, va, "R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule